// File: doc/BRIEF.md
# Ping-Pong Descriptor Channel Tracker

This block keeps track of one channel's pair of alternating hardware buffer descriptors. A producer hands in a buffer (address and byte size). The tracker validates it, writes it into whichever descriptor slot is next in fill order, and marks that slot ready with its length stored as size minus one. The DMA side reports each finished slot through a done input and an optional error input. The tracker picks up finished slots strictly in drain order and clears their done, error and ready flags. Each slot it clears counts as one completion request.

A consumer then runs service steps. Each step turns one outstanding completion into one "done buffer", and the consumer retires those done buffers in batches. The tracker keeps three things apart: completion detection (request counter), consumer acknowledgement (service counter), and channel occupancy (a level capped at two). Because of this separation, enqueue overflow, service underflow and retire underflow are each reported as a separate error pulse. An init pulse returns the whole channel to its empty state in one cycle.

Top module: `pingpong_tracker`

## Requirements
- R1: After reset, and on every cycle of reset, all descriptor flags, lengths and addresses are zero, `chanStatus` is 0, `doneCount` is 0, `canAccept` is 1, and every error or accept pulse is 0.
- R2: An enqueue with size in 1..2^LEN_W while fewer than two buffers are outstanding loads the slot selected by the fill index. The cycle after the request, that slot has ready=1, length = size-1, the given address, and start = `asyncMode`, and `enqAccept` pulses. The fill index starts at slot 0 and alternates on each accepted enqueue.
- R3: An enqueue with a valid size while two buffers are outstanding raises `enqOverflow` for one cycle and leaves the descriptors and the level unchanged.
- R4: An enqueue of size 0 or size greater than 2^LEN_W raises `enqBadSize` for one cycle and changes nothing. The size check takes precedence over the overflow check.
- R5: A `doneIn[i]` pulse sets slot i's done flag and `chanStatus`. An `errIn[i]` pulse sets slot i's error flag.
- R6: When the slot under the drain index has its done flag set, the next clock clears that slot's done, error and ready flags, clears `chanStatus` (unless a new done pulse arrives in the same cycle), counts one completion request and toggles the drain index. A done flag on the other slot is left alone until the drain index reaches it.
- R7: If both slots are done at once, they are drained on two consecutive clocks, the drain-index slot first.
- R8: A `svcReq` while the service count differs from the request count advances the service count. If the level is zero it instead pulses `svcUnderflow`. Otherwise it lowers the level by one and raises `doneCount` by one. A `svcReq` with equal counts has no effect.
- R9: `retValid` with `retCount` greater than `doneCount` pulses `retUnderflow` and leaves `doneCount` unchanged. Otherwise `retCount` is subtracted from `doneCount`.
- R10: `canAccept` is 1 exactly while fewer than two buffers are outstanding.
- R11: An `init` pulse clears both indices, the level, both counters, `doneCount`, all descriptor fields and `chanStatus` in one cycle, overriding any other input that cycle.
- R12: An accepted enqueue and a successful service step in the same cycle leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous channel re-initialisation pulse |
| asyncMode | input | 1 | 1 = control/asynchronous channel (sets packet-start on load) |
| enqValid | input | 1 | Enqueue request |
| enqAddr | input | ADDR_W | Buffer address |
| enqSize | input | LEN_W+1 | Buffer size in bytes |
| enqAccept | output | 1 | Enqueue accepted (one cycle after request) |
| enqOverflow | output | 1 | Enqueue rejected, two buffers outstanding |
| enqBadSize | output | 1 | Enqueue rejected, size out of range |
| doneIn | input | 2 | Per-slot completion report from the DMA |
| errIn | input | 2 | Per-slot error report from the DMA |
| descReady | output | 2 | Per-slot ready flag |
| descStart | output | 2 | Per-slot packet-start flag |
| descDone | output | 2 | Per-slot done flag |
| descErr | output | 2 | Per-slot error flag |
| descLen | output | 2*LEN_W | Per-slot length field (size-1), slot 0 in the low bits |
| descAddr | output | 2*ADDR_W | Per-slot buffer address, slot 0 in the low bits |
| chanStatus | output | 1 | Channel completion status |
| svcReq | input | 1 | Service step request |
| svcUnderflow | output | 1 | Service step found level zero |
| retValid | input | 1 | Retire request |
| retCount | input | CNT_W | Number of buffers to retire |
| retUnderflow | output | 1 | Retire asked for more than are done |
| doneCount | output | CNT_W | Completed buffers not yet retired |
| canAccept | output | 1 | Channel can take another buffer |

## Verification
The assertions assume nothing about how the producer or consumer handshake. A done report may land on any slot at any time, including an idle one. This freedom is what makes service underflow reachable. The only inputs the checks rely on are reset and init: both must be seen on a clock edge before the registered error pulses carry meaning. The stimulus combines directed sequences with a long random phase. The directed sequences cover fill order, overflow, bad sizes, an out-of-order done, a double completion, service and retire underflow, a simultaneous enqueue plus service, and init. The random phase issues every kind of pulse together, including done reports on idle slots and occasional init. A behavioural model follows it each cycle.

// File: rtl/pingpong_pkg.sv
package pingpong_pkg;

  localparam int NUM_SLOTS = 2;
  localparam int IDX_W     = 1;

  // Strobes from the control section to the slot datapath
  typedef struct packed {
    logic             initAll;
    logic             load;
    logic [IDX_W-1:0] loadIdx;
    logic             clear;
    logic [IDX_W-1:0] clearIdx;
  } slot_strobe_t;

endpackage

// File: rtl/pingpong_ctrl.sv
module pingpong_ctrl
  import pingpong_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 init,
  input  logic                 enqValid,
  input  logic [LEN_W:0]       enqSize,
  input  logic [NUM_SLOTS-1:0] slotDone,
  input  logic                 svcReq,
  input  logic                 retValid,
  input  logic [CNT_W-1:0]     retCount,
  output slot_strobe_t         strb,
  output logic                 enqAccept,
  output logic                 enqOverflow,
  output logic                 enqBadSize,
  output logic                 svcUnderflow,
  output logic                 retUnderflow,
  output logic [1:0]           level,
  output logic [CNT_W-1:0]     doneCount,
  output logic                 canAccept
);

  localparam logic [LEN_W:0] MAX_SIZE = {1'b1, {LEN_W{1'b0}}};
  localparam logic [1:0]     LEVEL_FULL = 2'd2;

  logic [IDX_W-1:0] fillIdx;
  logic [IDX_W-1:0] drainIdx;
  logic [CNT_W-1:0] reqCnt;
  logic [CNT_W-1:0] svcCnt;

  logic             sizeBad;
  logic             ovf;
  logic             acc;
  logic             compGo;
  logic             svcGo;
  logic             svcUnd;
  logic             svcOk;
  logic             retBad;
  logic             retOk;
  logic [1:0]       levelNext;
  logic [CNT_W-1:0] doneNext;

  always_comb begin
    sizeBad = enqValid && ((enqSize == '0) || (enqSize > MAX_SIZE));
    ovf     = enqValid && !sizeBad && (level >= LEVEL_FULL);
    acc     = enqValid && !sizeBad && !ovf;
    compGo  = slotDone[drainIdx];
    svcGo   = svcReq && (svcCnt != reqCnt);
    svcUnd  = svcGo && (level == 2'd0);
    svcOk   = svcGo && !svcUnd;
    retBad  = retValid && (retCount > doneCount);
    retOk   = retValid && !retBad;
  end

  always_comb begin
    levelNext = level;
    if (acc && !svcOk)      levelNext = level + 2'd1;
    else if (!acc && svcOk) levelNext = level - 2'd1;
    doneNext = doneCount + CNT_W'(svcOk) - (retOk ? retCount : '0);
  end

  always_comb begin
    strb          = '0;
    strb.initAll  = init;
    strb.load     = acc && !init;
    strb.loadIdx  = fillIdx;
    strb.clear    = compGo && !init;
    strb.clearIdx = drainIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillIdx      <= '0;
      drainIdx     <= '0;
      reqCnt       <= '0;
      svcCnt       <= '0;
      level        <= '0;
      doneCount    <= '0;
      enqAccept    <= 1'b0;
      enqOverflow  <= 1'b0;
      enqBadSize   <= 1'b0;
      svcUnderflow <= 1'b0;
      retUnderflow <= 1'b0;
    end else if (init) begin
      fillIdx      <= '0;
      drainIdx     <= '0;
      reqCnt       <= '0;
      svcCnt       <= '0;
      level        <= '0;
      doneCount    <= '0;
      enqAccept    <= 1'b0;
      enqOverflow  <= 1'b0;
      enqBadSize   <= 1'b0;
      svcUnderflow <= 1'b0;
      retUnderflow <= 1'b0;
    end else begin
      enqAccept    <= acc;
      enqOverflow  <= ovf;
      enqBadSize   <= sizeBad;
      svcUnderflow <= svcUnd;
      retUnderflow <= retBad;
      if (acc)    fillIdx  <= fillIdx + 1'b1;
      if (compGo) begin
        drainIdx <= drainIdx + 1'b1;
        reqCnt   <= reqCnt + 1'b1;
      end
      if (svcGo)  svcCnt   <= svcCnt + 1'b1;
      level     <= levelNext;
      doneCount <= doneNext;
    end
  end

  assign canAccept = (level < LEVEL_FULL);

endmodule

// File: rtl/pingpong_slots.sv
module pingpong_slots
  import pingpong_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  slot_strobe_t                strb,
  input  logic                        asyncMode,
  input  logic [ADDR_W-1:0]           enqAddr,
  input  logic [LEN_W:0]              enqSize,
  input  logic [NUM_SLOTS-1:0]        doneIn,
  input  logic [NUM_SLOTS-1:0]        errIn,
  output logic [NUM_SLOTS-1:0]        descReady,
  output logic [NUM_SLOTS-1:0]        descStart,
  output logic [NUM_SLOTS-1:0]        descDone,
  output logic [NUM_SLOTS-1:0]        descErr,
  output logic [NUM_SLOTS*LEN_W-1:0]  descLen,
  output logic [NUM_SLOTS*ADDR_W-1:0] descAddr,
  output logic                        chanStatus
);

  logic [LEN_W-1:0] lenField;
  assign lenField = LEN_W'(enqSize - 1'b1);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic hitLoad;
    logic hitClear;
    assign hitLoad  = strb.load  && (strb.loadIdx  == IDX_W'(g));
    assign hitClear = strb.clear && (strb.clearIdx == IDX_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        descReady[g]               <= 1'b0;
        descStart[g]               <= 1'b0;
        descDone[g]                <= 1'b0;
        descErr[g]                 <= 1'b0;
        descLen[g*LEN_W +: LEN_W]  <= '0;
        descAddr[g*ADDR_W +: ADDR_W] <= '0;
      end else if (strb.initAll) begin
        descReady[g]               <= 1'b0;
        descStart[g]               <= 1'b0;
        descDone[g]                <= 1'b0;
        descErr[g]                 <= 1'b0;
        descLen[g*LEN_W +: LEN_W]  <= '0;
        descAddr[g*ADDR_W +: ADDR_W] <= '0;
      end else begin
        // drain first, new reports next, a fresh load last
        if (hitClear) begin
          descDone[g]  <= 1'b0;
          descErr[g]   <= 1'b0;
          descReady[g] <= 1'b0;
        end
        if (doneIn[g]) descDone[g] <= 1'b1;
        if (errIn[g])  descErr[g]  <= 1'b1;
        if (hitLoad) begin
          descReady[g]                 <= 1'b1;
          descStart[g]                 <= asyncMode;
          descLen[g*LEN_W +: LEN_W]    <= lenField;
          descAddr[g*ADDR_W +: ADDR_W] <= enqAddr;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              chanStatus <= 1'b0;
    else if (strb.initAll)  chanStatus <= 1'b0;
    else if (|doneIn)       chanStatus <= 1'b1;
    else if (strb.clear)    chanStatus <= 1'b0;
  end

endmodule

// File: rtl/pingpong_tracker.sv
module pingpong_tracker
  import pingpong_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12,
  parameter int CNT_W  = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        init,
  input  logic                        asyncMode,
  input  logic                        enqValid,
  input  logic [ADDR_W-1:0]           enqAddr,
  input  logic [LEN_W:0]              enqSize,
  output logic                        enqAccept,
  output logic                        enqOverflow,
  output logic                        enqBadSize,
  input  logic [NUM_SLOTS-1:0]        doneIn,
  input  logic [NUM_SLOTS-1:0]        errIn,
  output logic [NUM_SLOTS-1:0]        descReady,
  output logic [NUM_SLOTS-1:0]        descStart,
  output logic [NUM_SLOTS-1:0]        descDone,
  output logic [NUM_SLOTS-1:0]        descErr,
  output logic [NUM_SLOTS*LEN_W-1:0]  descLen,
  output logic [NUM_SLOTS*ADDR_W-1:0] descAddr,
  output logic                        chanStatus,
  input  logic                        svcReq,
  output logic                        svcUnderflow,
  input  logic                        retValid,
  input  logic [CNT_W-1:0]            retCount,
  output logic                        retUnderflow,
  output logic [CNT_W-1:0]            doneCount,
  output logic                        canAccept
);

  slot_strobe_t strb;
  logic [1:0]   levelW;

  pingpong_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .init         (init),
    .enqValid     (enqValid),
    .enqSize      (enqSize),
    .slotDone     (descDone),
    .svcReq       (svcReq),
    .retValid     (retValid),
    .retCount     (retCount),
    .strb         (strb),
    .enqAccept    (enqAccept),
    .enqOverflow  (enqOverflow),
    .enqBadSize   (enqBadSize),
    .svcUnderflow (svcUnderflow),
    .retUnderflow (retUnderflow),
    .level        (levelW),
    .doneCount    (doneCount),
    .canAccept    (canAccept)
  );

  pingpong_slots #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_slots (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .asyncMode  (asyncMode),
    .enqAddr    (enqAddr),
    .enqSize    (enqSize),
    .doneIn     (doneIn),
    .errIn      (errIn),
    .descReady  (descReady),
    .descStart  (descStart),
    .descDone   (descDone),
    .descErr    (descErr),
    .descLen    (descLen),
    .descAddr   (descAddr),
    .chanStatus (chanStatus)
  );

endmodule

// File: rtl/pingpong_tracker_chk.sv
module pingpong_tracker_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             init,
  input logic             enqAccept,
  input logic             enqOverflow,
  input logic             enqBadSize,
  input logic             svcUnderflow,
  input logic             canAccept,
  input logic [1:0]       descReady,
  input logic [1:0]       lvl,
  input logic [CNT_W-1:0] doneCount
);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    enqOverflow |-> ($past(lvl) == 2'd2));

  a_r4_one_verdict: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({enqAccept, enqOverflow, enqBadSize}));

  a_r2_loaded_ready: assert property (@(posedge clk) disable iff (!rstN)
    enqAccept |-> (descReady != 2'b00));

  a_r10_accept_gate: assert property (@(posedge clk) disable iff (!rstN)
    enqAccept |-> $past(canAccept));

  a_r8_underflow_level: assert property (@(posedge clk) disable iff (!rstN)
    svcUnderflow |-> ($past(lvl) == 2'd0));

  a_r11_init_empty: assert property (@(posedge clk) disable iff (!rstN)
    init |=> ((lvl == 2'd0) && (doneCount == '0) && (descReady == 2'b00)));

endmodule

bind pingpong_tracker pingpong_tracker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .init         (init),
  .enqAccept    (enqAccept),
  .enqOverflow  (enqOverflow),
  .enqBadSize   (enqBadSize),
  .svcUnderflow (svcUnderflow),
  .canAccept    (canAccept),
  .descReady    (descReady),
  .lvl          (levelW),
  .doneCount    (doneCount)
);

// File: tb/pingpong_tracker_tb.sv
module pingpong_tracker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 12;
  localparam int CNT_W  = 8;
  localparam int MAXSZ  = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic init = 1'b0, asyncMode = 1'b0, enqValid = 1'b0;
  logic [ADDR_W-1:0] enqAddr = '0;
  logic [LEN_W:0] enqSize = '0;
  logic [1:0] doneIn = '0, errIn = '0;
  logic svcReq = 1'b0, retValid = 1'b0;
  logic [CNT_W-1:0] retCount = '0;

  logic enqAccept, enqOverflow, enqBadSize, chanStatus;
  logic svcUnderflow, retUnderflow, canAccept;
  logic [1:0] descReady, descStart, descDone, descErr;
  logic [2*LEN_W-1:0] descLen;
  logic [2*ADDR_W-1:0] descAddr;
  logic [CNT_W-1:0] doneCount;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pingpong_tracker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .init(init), .asyncMode(asyncMode),
    .enqValid(enqValid), .enqAddr(enqAddr), .enqSize(enqSize),
    .enqAccept(enqAccept), .enqOverflow(enqOverflow), .enqBadSize(enqBadSize),
    .doneIn(doneIn), .errIn(errIn),
    .descReady(descReady), .descStart(descStart), .descDone(descDone),
    .descErr(descErr), .descLen(descLen), .descAddr(descAddr),
    .chanStatus(chanStatus), .svcReq(svcReq), .svcUnderflow(svcUnderflow),
    .retValid(retValid), .retCount(retCount), .retUnderflow(retUnderflow),
    .doneCount(doneCount), .canAccept(canAccept)
  );

  // ---------------- behavioural reference model ----------------
  int mFill, mDrain, mLevel, mReq, mSvc, mDoneCnt;
  int mRdy[2], mSt[2], mDn[2], mEr[2], mLen[2];
  logic [ADDR_W-1:0] mAddr[2];
  int mStat, mAcc, mOvf, mBad, mSvcU, mRetU;

  task automatic model_clear();
    mFill = 0; mDrain = 0; mLevel = 0; mReq = 0; mSvc = 0; mDoneCnt = 0;
    mStat = 0; mAcc = 0; mOvf = 0; mBad = 0; mSvcU = 0; mRetU = 0;
    for (int i = 0; i < 2; i++) begin
      mRdy[i] = 0; mSt[i] = 0; mDn[i] = 0; mEr[i] = 0; mLen[i] = 0; mAddr[i] = '0;
    end
  endtask

  always @(posedge clk) begin : model
    int sz, acc, bad, ovf, comp, svcGo, und, svcOk, retBad, dr;
    if (!rstN || init) begin
      model_clear();
    end else begin
      sz = int'(enqSize);
      bad = (enqValid && (sz == 0 || sz > MAXSZ)) ? 1 : 0;
      ovf = (enqValid && !bad && mLevel >= 2) ? 1 : 0;
      acc = (enqValid && !bad && !ovf) ? 1 : 0;
      dr = mDrain;
      comp = mDn[dr];
      svcGo = (svcReq && mSvc != mReq) ? 1 : 0;
      und = (svcGo && mLevel == 0) ? 1 : 0;
      svcOk = svcGo && !und;
      retBad = (retValid && int'(retCount) > mDoneCnt) ? 1 : 0;
      if (comp) begin mDn[dr] = 0; mEr[dr] = 0; mRdy[dr] = 0; end
      for (int i = 0; i < 2; i++) begin
        if (doneIn[i]) mDn[i] = 1;
        if (errIn[i]) mEr[i] = 1;
      end
      if (acc) begin
        mRdy[mFill] = 1; mSt[mFill] = asyncMode; mLen[mFill] = sz - 1;
        mAddr[mFill] = enqAddr;
      end
      if (doneIn != 0) mStat = 1; else if (comp) mStat = 0;
      mLevel = mLevel + acc - svcOk;
      mDoneCnt = (mDoneCnt + svcOk - ((retValid && !retBad) ? int'(retCount) : 0)) & 255;
      if (acc) mFill ^= 1;
      if (comp) begin mDrain ^= 1; mReq = (mReq + 1) & 255; end
      if (svcGo) mSvc = (mSvc + 1) & 255;
      mAcc = acc; mOvf = ovf; mBad = bad; mSvcU = und; mRetU = retBad;
    end
  end

  // ---------------- checking ----------------
  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R2", "enqAccept", enqAccept, mAcc);
    check("R3", "enqOverflow", enqOverflow, mOvf);
    check("R4", "enqBadSize", enqBadSize, mBad);
    check("R8", "svcUnderflow", svcUnderflow, mSvcU);
    check("R9", "retUnderflow", retUnderflow, mRetU);
    check("R9", "doneCount", doneCount, mDoneCnt);
    check("R10", "canAccept", canAccept, (mLevel < 2));
    check("R5", "chanStatus", chanStatus, mStat);
    for (int i = 0; i < 2; i++) begin
      check("R2", "descReady", descReady[i], mRdy[i]);
      check("R2", "descStart", descStart[i], mSt[i]);
      check("R2", "descLen", descLen[i*LEN_W +: LEN_W], mLen[i]);
      check("R2", "descAddr", descAddr[i*ADDR_W +: ADDR_W], mAddr[i]);
      check("R6", "descDone", descDone[i], mDn[i]);
      check("R6", "descErr", descErr[i], mEr[i]);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    init = 0; enqValid = 0; doneIn = '0; errIn = '0; svcReq = 0; retValid = 0;
  endtask

  task automatic enq(input logic am, input int sz, input logic [ADDR_W-1:0] a);
    asyncMode = am; enqValid = 1; enqSize = (LEN_W+1)'(sz); enqAddr = a;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : stim
    model_clear();
    repeat (2) @(negedge clk);
    // R1: outputs during and right after reset
    check("R1", "canAccept", canAccept, 1);
    check("R1", "descReady", descReady, 0);
    check("R1", "doneCount", doneCount, 0);
    rstN = 1;
    tick();
    check("R1", "chanStatus", chanStatus, 0);

    // R2: fill order slot0 then slot1
    enq(1, 100, 32'hA000_0000); tick();
    check("R2", "slot0 ready", descReady, 2'b01);
    check("R2", "slot0 len", descLen[LEN_W-1:0], 99);
    check("R2", "slot0 start", descStart[0], 1);
    enq(0, MAXSZ, 32'hB000_0000); tick();
    check("R2", "slot1 ready", descReady, 2'b11);
    check("R2", "slot1 len max", descLen[2*LEN_W-1:LEN_W], MAXSZ - 1);
    check("R10", "full", canAccept, 0);
    // R3 overflow
    enq(1, 10, 32'hC); tick();
    check("R3", "overflow", enqOverflow, 1);
    // R4 bad sizes, precedence over overflow
    enq(1, 0, 32'hD); tick();
    check("R4", "zero size", enqBadSize, 1);
    enq(1, MAXSZ + 1, 32'hE); tick();
    check("R4", "oversize", enqBadSize, 1);
    check("R4", "no overflow", enqOverflow, 0);

    // R6: done on non-drain slot waits
    doneIn = 2'b10; errIn = 2'b10; tick();
    check("R5", "status", chanStatus, 1);
    tick();
    check("R6", "slot1 held", descDone, 2'b10);
    // R7: drain slot0 then slot1 on consecutive clocks
    doneIn = 2'b01; tick();
    tick();
    check("R7", "slot0 drained", descDone, 2'b10);
    tick();
    check("R7", "slot1 drained", descDone, 2'b00);
    check("R6", "status cleared", chanStatus, 0);

    // R8 service steps
    svcReq = 1; tick();
    svcReq = 1; tick();
    check("R8", "two done", doneCount, 2);
    svcReq = 1; tick();
    check("R8", "equal counts ignored", doneCount, 2);
    // R9 retire
    retValid = 1; retCount = 3; tick();
    check("R9", "retire underflow", retUnderflow, 1);
    check("R9", "count kept", doneCount, 2);
    retValid = 1; retCount = 2; tick();
    check("R9", "retired", doneCount, 0);
    // R8 underflow via a done on an idle slot
    doneIn = 2'b01; tick(); tick();
    svcReq = 1; tick();
    check("R8", "service underflow", svcUnderflow, 1);

    // R12 enqueue + service in same cycle
    enq(1, 8, 32'h10); tick();
    doneIn = 2'b10; tick(); tick();
    enq(1, 8, 32'h20); svcReq = 1; tick();
    check("R12", "level held", canAccept, 1);
    check("R12", "done bumped", doneCount, 1);
    enq(1, 8, 32'h30); tick();
    check("R12", "now full", canAccept, 0);

    // R11 init
    init = 1; enq(1, 8, 32'h40); doneIn = 2'b11; tick();
    check("R11", "cleared ready", descReady, 0);
    check("R11", "cleared count", doneCount, 0);
    check("R11", "no accept", enqAccept, 0);

    // random phase against the model
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 2) == 0)
        enq(1'($urandom_range(0, 1)), int'($urandom_range(0, MAXSZ + 2)), $urandom);
      if ($urandom_range(0, 3) == 0) doneIn = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 5) == 0) errIn = 2'($urandom_range(0, 3));
      svcReq = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 3) == 0) begin
        retValid = 1; retCount = CNT_W'($urandom_range(0, 3));
      end
      init = ($urandom_range(0, 99) == 0);
      tick();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule